// File: doc/BRIEF.md
# CAN Controller Operating-Mode Sequencer

This block decides which operating mode a CAN controller core is in and reacts to the register writes that change that mode. A simple write port (address, data, strobe) reaches four registers: a control register with an enable bit and a soft-reset bit, a mode register with three request bits, an 8-bit baud prescaler and a 9-bit bit-timing word. From the enable bit and the mode request bits the block derives a one-hot status: config, normal, loopback, sleep or snoop. The prescaler and bit-timing words can only be changed while the core sits in config.

Two state machines make up the block. The mode machine has the states MS_CONFIG, MS_NORMAL, MS_LOOPBACK, MS_SLEEP and MS_SNOOP. Its next state comes from the next enable and mode bits. MS_CONFIG applies whenever enable is 0. Otherwise loopback wins over sleep, sleep wins over snoop, and normal applies when no request bit is set. Two transitions raise event pulses. Entering MS_SLEEP from any other state raises the sleep pulse. Going from MS_SLEEP to MS_NORMAL raises the wake pulse. While the machine is in MS_SLEEP, a received bus frame or a finished transmission clears the sleep request bit, and the mode is then worked out again.

The kick machine has the states KS_IDLE, KS_HPB and KS_FIFO. A control write that leaves the core enabled moves it to KS_HPB. It then steps to KS_FIFO and back to KS_IDLE. A control write that disables the core sends it straight to KS_IDLE. The high-priority-buffer request is driven in KS_HPB and the TX-FIFO request in KS_FIFO, so a transmit unit sees the two requests in that order. The same write also clears the timestamp counter. A write that leaves the core disabled pulses a clear to the error counters and the interrupt flags of the neighbouring blocks.

Top module: `can_mode_ctrl`

## Requirements
- R1: After rst_n the status is 5'b00001 (config only), the mode bits, prescaler and bit-timing word are 0, and every event pulse is low.
- R2: The status outputs are exactly one-hot, with bit 0 config, bit 1 normal, bit 2 loopback, bit 3 sleep and bit 4 snoop. They change in the clock cycle after the write, and show config whenever the enable bit (control register at address 0, bit 1) is 0.
- R3: With enable set, the mode register (address 1; bit 0 sleep, bit 1 loopback, bit 2 snoop) selects loopback over sleep over snoop, and normal when all three bits are 0.
- R4: While enabled, a mode-register write updates only the sleep bit. The loopback and snoop bits keep their values. In config all three bits are written.
- R5: Writes to the prescaler (address 2, data bits 7:0) or the bit-timing word (address 3, data bits 8:0) are ignored while enabled and take effect in config.
- R6: A control write with the soft-reset bit (bit 0) set clears the mode bits, prescaler and bit-timing word and leaves the core in config, whatever bit 1 holds.
- R7: A control write that leaves the core disabled pulses cfg_clear high for exactly the cycle after the write.
- R8: A control write that leaves the core enabled pulses ts_clear and kick_hpb in the cycle after the write, then kick_fifo alone in the next cycle, and nothing in the cycle after that.
- R9: sleep_irq pulses for one cycle when the status enters sleep from any other status.
- R10: wake_irq pulses for one cycle when the status goes from sleep to normal, and never when sleep is left for snoop or config.
- R11: rx_frame_seen or tx_done in a cycle where the status is sleep clears the sleep mode bit. In any other status these inputs change nothing, and a write in the same cycle does not stop the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word address |
| wr_data | input | 9 | Register write data |
| rx_frame_seen | input | 1 | A bus frame was received this cycle |
| tx_done | input | 1 | A transmission completed this cycle |
| status | output | 5 | One-hot mode status |
| mode_bits | output | 3 | Mode request bits (snoop, loopback, sleep) |
| prescaler | output | 8 | Baud prescaler value |
| bit_timing | output | 9 | Bit-timing word |
| sleep_irq | output | 1 | Entered-sleep pulse |
| wake_irq | output | 1 | Woke-to-normal pulse |
| cfg_clear | output | 1 | Config-entry clear pulse |
| ts_clear | output | 1 | Timestamp clear pulse |
| kick_hpb | output | 1 | Send high-priority buffer request |
| kick_fifo | output | 1 | Send TX FIFO request |

## Verification
The assertions take it for granted that a control write that enables the core is never followed by another control write while the kick machine is in KS_HPB. Such a write would restart the sequence and break the hpb-then-fifo order that the kick check relies on. They also assume that rx_frame_seen and tx_done are single-cycle pulses. The stimulus keeps to both rules: every register access is a one-cycle strobe with idle cycles around it, the kick sequence is always allowed to finish before the next control write, and event pulses are never applied on the same cycle as a write.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    localparam int MODE_W         = 3;
    localparam int STATUS_W       = 5;

    localparam int CTRL_SRST_BIT  = 0;
    localparam int CTRL_EN_BIT    = 1;

    localparam int MODE_SLEEP_BIT = 0;
    localparam int MODE_LOOP_BIT  = 1;
    localparam int MODE_SNOOP_BIT = 2;

    localparam int ST_CONFIG      = 0;
    localparam int ST_NORMAL      = 1;
    localparam int ST_LOOP        = 2;
    localparam int ST_SLEEP       = 3;
    localparam int ST_SNOOP       = 4;

    typedef enum logic [2:0] {
        MS_CONFIG,
        MS_NORMAL,
        MS_LOOPBACK,
        MS_SLEEP,
        MS_SNOOP
    } mode_state_e;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_HPB,
        KS_FIFO
    } kick_state_e;

    // Fixed priority: loopback, then sleep, then snoop, else normal.
    function automatic mode_state_e pick_mode(input logic en, input logic [MODE_W-1:0] req);
        mode_state_e s;
        if (!en)                       s = MS_CONFIG;
        else if (req[MODE_LOOP_BIT])   s = MS_LOOPBACK;
        else if (req[MODE_SLEEP_BIT])  s = MS_SLEEP;
        else if (req[MODE_SNOOP_BIT])  s = MS_SNOOP;
        else                           s = MS_NORMAL;
        return s;
    endfunction

    function automatic logic [STATUS_W-1:0] to_status(input mode_state_e s);
        logic [STATUS_W-1:0] v;
        v = '0;
        unique case (s)
            MS_CONFIG:   v[ST_CONFIG] = 1'b1;
            MS_NORMAL:   v[ST_NORMAL] = 1'b1;
            MS_LOOPBACK: v[ST_LOOP]   = 1'b1;
            MS_SLEEP:    v[ST_SLEEP]  = 1'b1;
            MS_SNOOP:    v[ST_SNOOP]  = 1'b1;
            default:     v[ST_CONFIG] = 1'b1;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/can_mode_regs.sv
module can_mode_regs
    import can_mode_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int PRESC_W     = 8,
    parameter int TIMING_W    = 9,
    parameter int ADDR_CTRL   = 0,
    parameter int ADDR_MODE   = 1,
    parameter int ADDR_PRESC  = 2,
    parameter int ADDR_TIMING = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [TIMING_W-1:0] wr_data,
    input  logic                sleep_exit,
    output logic                enable_d,
    output logic [MODE_W-1:0]   mode_d,
    output logic [MODE_W-1:0]   mode_q,
    output logic [PRESC_W-1:0]  presc_q,
    output logic [TIMING_W-1:0] timing_q,
    output logic                evt_on,
    output logic                evt_cfg
);

    logic                enable_q;
    logic [PRESC_W-1:0]  presc_d;
    logic [TIMING_W-1:0] timing_d;
    logic                wr_ctrl, wr_mode, wr_presc, wr_timing;

    assign wr_ctrl   = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
    assign wr_mode   = wr_en && (wr_addr == ADDR_W'(ADDR_MODE));
    assign wr_presc  = wr_en && (wr_addr == ADDR_W'(ADDR_PRESC));
    assign wr_timing = wr_en && (wr_addr == ADDR_W'(ADDR_TIMING));

    always_comb begin
        enable_d = enable_q;
        mode_d   = mode_q;
        presc_d  = presc_q;
        timing_d = timing_q;

        if (wr_ctrl) begin
            enable_d = wr_data[CTRL_EN_BIT] & ~wr_data[CTRL_SRST_BIT];
            if (wr_data[CTRL_SRST_BIT]) begin
                mode_d   = '0;
                presc_d  = '0;
                timing_d = '0;
            end
        end

        if (wr_mode) begin
            if (!enable_q) mode_d = wr_data[MODE_W-1:0];
            else           mode_d[MODE_SLEEP_BIT] = wr_data[MODE_SLEEP_BIT];
        end

        if (wr_presc && !enable_q)  presc_d  = wr_data[PRESC_W-1:0];
        if (wr_timing && !enable_q) timing_d = wr_data;

        // Bus or transmit activity in sleep overrides a same-cycle write.
        if (sleep_exit) mode_d[MODE_SLEEP_BIT] = 1'b0;
    end

    assign evt_on  = wr_ctrl && enable_d;
    assign evt_cfg = wr_ctrl && !enable_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
            mode_q   <= '0;
            presc_q  <= '0;
            timing_q <= '0;
        end else begin
            enable_q <= enable_d;
            mode_q   <= mode_d;
            presc_q  <= presc_d;
            timing_q <= timing_d;
        end
    end

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
    import can_mode_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable_d,
    input  logic [MODE_W-1:0]   mode_d,
    input  logic                rx_frame_seen,
    input  logic                tx_done,
    output logic                sleep_exit,
    output logic [STATUS_W-1:0] status,
    output logic                sleep_irq,
    output logic                wake_irq
);

    mode_state_e state_q, state_d;

    assign sleep_exit = (state_q == MS_SLEEP) && (rx_frame_seen || tx_done);
    assign state_d    = pick_mode(enable_d, mode_d);
    assign status     = to_status(state_q);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MS_CONFIG;
        else        state_q <= state_d;
    end

    // Transition pulses.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sleep_irq <= 1'b0;
            wake_irq  <= 1'b0;
        end else begin
            unique case (state_q)
                MS_SLEEP: begin
                    sleep_irq <= 1'b0;
                    wake_irq  <= (state_d == MS_NORMAL);
                end
                MS_CONFIG, MS_NORMAL, MS_LOOPBACK, MS_SNOOP: begin
                    sleep_irq <= (state_d == MS_SLEEP);
                    wake_irq  <= 1'b0;
                end
                default: begin
                    sleep_irq <= 1'b0;
                    wake_irq  <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/can_kick_seq.sv
module can_kick_seq
    import can_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_on,
    input  logic evt_cfg,
    output logic kick_hpb,
    output logic kick_fifo,
    output logic ts_clear,
    output logic cfg_clear
);

    kick_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KS_IDLE: if (evt_on) state_d = KS_HPB;
            KS_HPB:  state_d = evt_on ? KS_HPB : (evt_cfg ? KS_IDLE : KS_FIFO);
            KS_FIFO: state_d = evt_on ? KS_HPB : KS_IDLE;
            default: state_d = KS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KS_IDLE;
        else        state_q <= state_d;
    end

    // Outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts_clear  <= 1'b0;
            cfg_clear <= 1'b0;
        end else begin
            ts_clear  <= evt_on;
            cfg_clear <= evt_cfg;
        end
    end

    assign kick_hpb  = (state_q == KS_HPB);
    assign kick_fifo = (state_q == KS_FIFO);

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
    import can_mode_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int PRESC_W     = 8,
    parameter int TIMING_W    = 9,
    parameter int ADDR_CTRL   = 0,
    parameter int ADDR_MODE   = 1,
    parameter int ADDR_PRESC  = 2,
    parameter int ADDR_TIMING = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [TIMING_W-1:0] wr_data,
    input  logic                rx_frame_seen,
    input  logic                tx_done,
    output logic [4:0]          status,
    output logic [2:0]          mode_bits,
    output logic [PRESC_W-1:0]  prescaler,
    output logic [TIMING_W-1:0] bit_timing,
    output logic                sleep_irq,
    output logic                wake_irq,
    output logic                cfg_clear,
    output logic                ts_clear,
    output logic                kick_hpb,
    output logic                kick_fifo
);

    logic              enable_d;
    logic [MODE_W-1:0] mode_d;
    logic              sleep_exit;
    logic              evt_on, evt_cfg;

    can_mode_regs #(
        .ADDR_W(ADDR_W), .PRESC_W(PRESC_W), .TIMING_W(TIMING_W),
        .ADDR_CTRL(ADDR_CTRL), .ADDR_MODE(ADDR_MODE),
        .ADDR_PRESC(ADDR_PRESC), .ADDR_TIMING(ADDR_TIMING)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sleep_exit(sleep_exit), .enable_d(enable_d),
        .mode_d(mode_d), .mode_q(mode_bits), .presc_q(prescaler),
        .timing_q(bit_timing), .evt_on(evt_on), .evt_cfg(evt_cfg)
    );

    can_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .enable_d(enable_d), .mode_d(mode_d),
        .rx_frame_seen(rx_frame_seen), .tx_done(tx_done),
        .sleep_exit(sleep_exit), .status(status),
        .sleep_irq(sleep_irq), .wake_irq(wake_irq)
    );

    can_kick_seq u_kick (
        .clk(clk), .rst_n(rst_n), .evt_on(evt_on), .evt_cfg(evt_cfg),
        .kick_hpb(kick_hpb), .kick_fifo(kick_fifo),
        .ts_clear(ts_clear), .cfg_clear(cfg_clear)
    );

endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk #(
    parameter int ADDR_W     = 2,
    parameter int PRESC_W    = 8,
    parameter int ADDR_CTRL  = 0,
    parameter int ADDR_MODE  = 1,
    parameter int ADDR_PRESC = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [1:0]         ctrl_bits,
    input logic [4:0]         status,
    input logic [2:0]         mode_bits,
    input logic [PRESC_W-1:0] prescaler,
    input logic               sleep_irq,
    input logic               wake_irq,
    input logic               cfg_clear,
    input logic               kick_hpb,
    input logic               kick_fifo
);

    logic wr_ctrl, wr_mode, wr_presc;
    assign wr_ctrl  = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
    assign wr_mode  = wr_en && (wr_addr == ADDR_W'(ADDR_MODE));
    assign wr_presc = wr_en && (wr_addr == ADDR_W'(ADDR_PRESC));

    AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n) $countones(status) == 1); // R2
    AST_DISABLE_TO_CONFIG: assert property (@(posedge clk) disable iff (!rst_n) (wr_ctrl && !ctrl_bits[1]) |=> status[0]); // R2
    AST_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n) status[3] |-> (mode_bits[0] && !mode_bits[1])); // R3
    AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n) (wr_mode && !status[0]) |=> (mode_bits[2:1] == $past(mode_bits[2:1]))); // R4
    AST_PRESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (wr_presc && !status[0]) |=> $stable(prescaler)); // R5
    AST_SRST_CONFIG: assert property (@(posedge clk) disable iff (!rst_n) (wr_ctrl && ctrl_bits[0]) |=> (status[0] && mode_bits == 3'b000)); // R6
    AST_CFG_PULSE: assert property (@(posedge clk) disable iff (!rst_n) cfg_clear |-> status[0]); // R7
    AST_KICK_ORDER: assert property (@(posedge clk) disable iff (!rst_n) kick_fifo |-> $past(kick_hpb)); // R8
    AST_SLEEP_IRQ: assert property (@(posedge clk) disable iff (!rst_n) sleep_irq |-> (status[3] && !$past(status[3]))); // R9
    AST_WAKE_IRQ: assert property (@(posedge clk) disable iff (!rst_n) wake_irq |-> (status[1] && $past(status[3]))); // R10

endmodule

bind can_mode_ctrl can_mode_ctrl_chk #(
    .ADDR_W(ADDR_W), .PRESC_W(PRESC_W), .ADDR_CTRL(ADDR_CTRL),
    .ADDR_MODE(ADDR_MODE), .ADDR_PRESC(ADDR_PRESC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .ctrl_bits(wr_data[1:0]), .status(status), .mode_bits(mode_bits),
    .prescaler(prescaler), .sleep_irq(sleep_irq), .wake_irq(wake_irq),
    .cfg_clear(cfg_clear), .kick_hpb(kick_hpb), .kick_fifo(kick_fifo)
);

// File: tb/sim_can_mode_ctrl.sv
module sim_can_mode_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;

    // {addr[1:0], data[3:0], status[4:0], mode[2:0], sleep_irq, wake_irq}
    localparam logic [15:0] VEC [NVEC] = '{
        {2'd1, 4'h7, 5'h01, 3'h7, 1'b0, 1'b0},
        {2'd0, 4'h2, 5'h04, 3'h7, 1'b0, 1'b0},
        {2'd1, 4'h0, 5'h04, 3'h6, 1'b0, 1'b0},
        {2'd0, 4'h0, 5'h01, 3'h6, 1'b0, 1'b0},
        {2'd1, 4'h5, 5'h01, 3'h5, 1'b0, 1'b0},
        {2'd0, 4'h2, 5'h08, 3'h5, 1'b1, 1'b0},
        {2'd1, 4'h4, 5'h10, 3'h4, 1'b0, 1'b0},
        {2'd1, 4'h1, 5'h08, 3'h5, 1'b1, 1'b0},
        {2'd0, 4'h3, 5'h01, 3'h0, 1'b0, 1'b0},
        {2'd0, 4'h2, 5'h02, 3'h0, 1'b0, 1'b0},
        {2'd1, 4'h3, 5'h08, 3'h1, 1'b1, 1'b0},
        {2'd1, 4'h0, 5'h02, 3'h0, 1'b0, 1'b1},
        {2'd1, 4'h1, 5'h08, 3'h1, 1'b1, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [8:0] wr_data = '0;
    logic       rx_frame_seen = 1'b0;
    logic       tx_done = 1'b0;
    logic [4:0] status;
    logic [2:0] mode_bits;
    logic [7:0] prescaler;
    logic [8:0] bit_timing;
    logic       sleep_irq, wake_irq, cfg_clear, ts_clear, kick_hpb, kick_fifo;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rx_frame_seen(rx_frame_seen), .tx_done(tx_done),
        .status(status), .mode_bits(mode_bits), .prescaler(prescaler),
        .bit_timing(bit_timing), .sleep_irq(sleep_irq), .wake_irq(wake_irq),
        .cfg_clear(cfg_clear), .ts_clear(ts_clear), .kick_hpb(kick_hpb),
        .kick_fifo(kick_fifo)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    // Returns at the falling edge after the write was sampled.
    task automatic write_reg(input logic [1:0] a, input logic [8:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_evt(input bit use_tx);
        @(negedge clk);
        if (use_tx) tx_done = 1'b1; else rx_frame_seen = 1'b1;
        @(negedge clk);
        tx_done = 1'b0; rx_frame_seen = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset status", 32'(status), 32'h01);
        chk("R1 reset mode", 32'(mode_bits), 0);
        chk("R1 reset prescaler/timing", {prescaler, 15'd0, bit_timing}, 0);
        chk("R1 reset pulses", {sleep_irq, wake_irq, cfg_clear, ts_clear, kick_hpb, kick_fifo}, 0);

        // Mode table: R2 R3 R4 R6 R9 R10
        for (int i = 0; i < NVEC; i++) begin
            write_reg(VEC[i][15:14], {5'd0, VEC[i][13:10]});
            chk($sformatf("R2 R3 R4 vec%0d status", i), 32'(status), 32'(VEC[i][9:5]));
            chk($sformatf("R4 R6 vec%0d mode", i), 32'(mode_bits), 32'(VEC[i][4:2]));
            chk($sformatf("R9 vec%0d sleep_irq", i), 32'(sleep_irq), 32'(VEC[i][1]));
            chk($sformatf("R10 vec%0d wake_irq", i), 32'(wake_irq), 32'(VEC[i][0]));
        end

        // Now in sleep with mode 3'b001.
        pulse_evt(1'b0);
        chk("R11 rx wakes status", 32'(status), 32'h02);
        chk("R11 rx clears sleep bit", 32'(mode_bits), 0);
        chk("R10 wake pulse on rx", 32'(wake_irq), 1);
        @(negedge clk);
        chk("R10 wake pulse one cycle", 32'(wake_irq), 0);

        write_reg(2'd1, 9'h001);
        chk("R9 sleep again", 32'(status), 32'h08);
        pulse_evt(1'b1);
        chk("R11 tx_done wakes", {27'd0, status}, 32'h02);
        chk("R11 tx_done clears sleep bit", 32'(mode_bits), 0);

        pulse_evt(1'b0);
        chk("R11 rx in normal no effect", {24'd0, mode_bits, status}, {24'd0, 3'd0, 5'h02});

        // Config entry and kick sequence.
        write_reg(2'd0, 9'h000);
        chk("R7 cfg_clear pulse", 32'(cfg_clear), 1);
        chk("R2 disabled is config", 32'(status), 32'h01);
        @(negedge clk);
        chk("R7 cfg_clear one cycle", 32'(cfg_clear), 0);
        write_reg(2'd1, 9'h003);
        write_reg(2'd0, 9'h002);
        chk("R3 loopback over sleep", 32'(status), 32'h04);
        chk("R8 first cycle hpb/ts/fifo", {ts_clear, kick_hpb, kick_fifo}, 3'b110);
        @(negedge clk);
        chk("R8 second cycle hpb/ts/fifo", {ts_clear, kick_hpb, kick_fifo}, 3'b001);
        @(negedge clk);
        chk("R8 third cycle idle", {ts_clear, kick_hpb, kick_fifo}, 3'b000);
        pulse_evt(1'b0);
        chk("R11 rx in loopback keeps sleep bit", 32'(mode_bits), 3);
        chk("R11 rx in loopback keeps status", 32'(status), 32'h04);

        // Timing register guard.
        write_reg(2'd0, 9'h000);
        write_reg(2'd2, 9'h05A);
        write_reg(2'd3, 9'h1AB);
        chk("R5 prescaler written in config", 32'(prescaler), 32'h5A);
        chk("R5 timing written in config", 32'(bit_timing), 32'h1AB);
        write_reg(2'd0, 9'h002);
        write_reg(2'd2, 9'h011);
        write_reg(2'd3, 9'h000);
        chk("R5 prescaler held while enabled", 32'(prescaler), 32'h5A);
        chk("R5 timing held while enabled", 32'(bit_timing), 32'h1AB);
        write_reg(2'd0, 9'h003);
        chk("R6 soft reset config", 32'(status), 32'h01);
        chk("R6 soft reset clears regs", {prescaler, mode_bits, bit_timing}, 0);
        chk("R7 soft reset cfg_clear", 32'(cfg_clear), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule